// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block builds a single-error-correcting Hamming code over one sector of data while a NAND controller moves it across the flash data bus. Each data beat comes with a valid strobe and a chip-select tag. The engine is bound to one chip select and absorbs only that device's beats. For every data bit it folds the bit into an even or an odd line parity. The bit's position inside its byte decides the three column terms, and the byte's index inside the sector decides the nine row terms. Together these give twelve even/odd pairs, from P1 up to P2048.

Software programs the bound chip select, the bus width and the sector length through a small register port. It clears the accumulator before a page transfer and reads the packed 32-bit code once the done flag rises. On an x16 device each beat carries two bytes, and the sector length is then counted in words. Parity is not inverted, so a fully erased sector gives a code of zero.

Top module: `ecc_hamming_acc`

## Requirements
- R1: Register address 0 is the configuration register. Bit 0 is the enable, bits 3:1 hold the bound chip-select number and bit 7 selects x16 width when it is 1. Reading address 0 returns those fields and zero in every other bit.
- R2: A write to address 1 with bit 8 set zeroes the code, the beat count and the done flag from the next cycle on. Bit 0 of the same write is stored as the result pointer and reads back at bit 0 of address 1. Bit 8 always reads back as 0.
- R3: Address 2 holds the sector length field in bits 31:22, equal to sector bytes / 2 - 1, and a 4-bit field in bits 3:0. Both fields read back unchanged.
- R4: Column terms P1, P2 and P4 take the XOR of the data bits whose bit index within the byte has bit 0, 1 or 2 clear (even term) or set (odd term).
- R5: Row terms P8 through P2048 take the XOR of the data bits whose byte index within the sector has bit 0 through bit 8 clear (even term) or set (odd term).
- R6: Address 3 reads the code with P1e..P128e in bits 0..7, P256e..P2048e in bits 8..11, P1o..P128o in bits 16..23 and P256o..P2048o in bits 24..27. All other bits read 0.
- R7: Parity is not inverted: the code starts at zero after a clear, and a 512-byte sector of all 0xFF bytes yields 0x00000000.
- R8: A beat whose chip-select tag differs from the bound chip select leaves the code and the count unchanged.
- R9: A beat that arrives while the enable bit is 0 leaves the code and the count unchanged.
- R10: Once the sector length in beats has been absorbed, the done output is 1. Further beats are ignored until the next clear.
- R11: In x16 mode a beat contributes its low byte at an even byte index and its high byte at the next index. The sector length is counted in 16-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 control, 2 size, 3 result) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| beat_valid | input | 1 | Data beat valid |
| beat_data | input | 16 | Data beat (x8 mode uses bits 7:0) |
| beat_cs | input | 3 | Chip-select tag of the beat |
| ecc_done | output | 1 | Sector fully absorbed |

## Verification
The hardest behaviour to reach is the edge of the sector. The final beat must raise done in the same cycle the count reaches the programmed length, and any beat after it must leave the code as it was. The stimulus uses a four-byte sector and checks done after the third beat and again after the fourth. It then sends more beats with different data and compares the code with a model of only the first four bytes. A similar boundary check in x16 mode, plus a hand-derived code for a single set bit, confirm the byte order within a word and the bit layout of the result.

// File: rtl/ecc_acc_pkg.sv
package ecc_acc_pkg;
    localparam int CS_W     = 3;
    localparam int SIZE_W   = 10;
    localparam int ROW_BITS = 9;
    localparam int COL_BITS = 3;
    localparam int TERMS    = COL_BITS + ROW_BITS;
    localparam int CNT_W    = SIZE_W + 2;

    typedef enum logic [1:0] {
        ADDR_CFG    = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_SIZE   = 2'd2,
        ADDR_RESULT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            wide;
        logic [CS_W-1:0] cs;
        logic            en;
    } cfg_t;
endpackage

// File: rtl/ecc_byte_par.sv
module ecc_byte_par
    import ecc_acc_pkg::*;
(
    input  logic [7:0]          byte_i,
    output logic [COL_BITS-1:0] even_o,
    output logic [COL_BITS-1:0] odd_o,
    output logic                total_o
);
    genvar k;
    generate
        for (k = 0; k < COL_BITS; k++) begin : g_col
            logic [7:0] sel_mask;
            always_comb begin
                for (int b = 0; b < 8; b++) begin
                    sel_mask[b] = ((b >> k) & 1) == 1;
                end
            end
            assign odd_o[k]  = ^(byte_i & sel_mask);
            assign even_o[k] = ^(byte_i & ~sel_mask);
        end
    endgenerate

    assign total_o = ^byte_i;
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
    import ecc_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output cfg_t              cfg_o,
    output logic              ptr_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [3:0]        nib_o,
    output logic              clear_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic              ptr;
        logic [SIZE_W-1:0] size;
        logic [3:0]        nib;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata_i[21:8], wdata_i[6:4]};

    always_comb begin
        st_d    = st_q;
        clear_o = 1'b0;
        if (wr_i) begin
            unique case (reg_addr_e'(addr_i))
                ADDR_CFG: begin
                    st_d.cfg.en   = wdata_i[0];
                    st_d.cfg.cs   = wdata_i[CS_W:1];
                    st_d.cfg.wide = wdata_i[7];
                end
                ADDR_CTRL: begin
                    st_d.ptr = wdata_i[0];
                    clear_o  = wdata_i[8];
                end
                ADDR_SIZE: begin
                    st_d.size = wdata_i[31:32-SIZE_W];
                    st_d.nib  = wdata_i[3:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign ptr_o  = st_q.ptr;
    assign size_o = st_q.size;
    assign nib_o  = st_q.nib;
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
    import ecc_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic              wide_i,
    input  logic [15:0]       data_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [TERMS-1:0]  even_o,
    output logic [TERMS-1:0]  odd_o,
    output logic              done_o
);
    localparam int LANES = 2;

    typedef struct packed {
        logic [TERMS-1:0] even;
        logic [TERMS-1:0] odd;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } acc_t;

    acc_t st_d, st_q;

    logic [COL_BITS-1:0] col_e [LANES];
    logic [COL_BITS-1:0] col_o [LANES];
    logic                tot   [LANES];
    logic [ROW_BITS-1:0] idx   [LANES];
    logic [CNT_W-1:0]    limit;
    logic [CNT_W-1:0]    cnt_inc;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            ecc_byte_par u_par (
                .byte_i  (data_i[8*l +: 8]),
                .even_o  (col_e[l]),
                .odd_o   (col_o[l]),
                .total_o (tot[l])
            );
        end
    endgenerate

    always_comb begin
        limit = {{(CNT_W-SIZE_W){1'b0}}, size_i} + 1'b1;
        if (!wide_i) limit = limit << 1;
        cnt_inc = st_q.cnt + 1'b1;
        idx[0]  = wide_i ? {st_q.cnt[ROW_BITS-2:0], 1'b0} : st_q.cnt[ROW_BITS-1:0];
        idx[1]  = {idx[0][ROW_BITS-1:1], 1'b1};

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (take_i && !st_q.done) begin
            for (int ln = 0; ln < LANES; ln++) begin
                if (ln == 0 || wide_i) begin
                    st_d.even[COL_BITS-1:0] = st_d.even[COL_BITS-1:0] ^ col_e[ln];
                    st_d.odd[COL_BITS-1:0]  = st_d.odd[COL_BITS-1:0]  ^ col_o[ln];
                    for (int r = 0; r < ROW_BITS; r++) begin
                        if (idx[ln][r]) st_d.odd[COL_BITS+r]  = st_d.odd[COL_BITS+r]  ^ tot[ln];
                        else            st_d.even[COL_BITS+r] = st_d.even[COL_BITS+r] ^ tot[ln];
                    end
                end
            end
            st_d.cnt = cnt_inc;
            if (cnt_inc == limit) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign even_o = st_q.even;
    assign odd_o  = st_q.odd;
    assign done_o = st_q.done;
endmodule

// File: rtl/ecc_hamming_acc.sv
module ecc_hamming_acc
    import ecc_acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            beat_valid,
    input  logic [15:0]     beat_data,
    input  logic [CS_W-1:0] beat_cs,
    output logic            ecc_done
);
    cfg_t              cfg;
    logic              ptr;
    logic [SIZE_W-1:0] size;
    logic [3:0]        nib;
    logic              clear;
    logic              take;
    logic [TERMS-1:0]  par_even;
    logic [TERMS-1:0]  par_odd;
    logic [31:0]       result;

    ecc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .cfg_o   (cfg),
        .ptr_o   (ptr),
        .size_o  (size),
        .nib_o   (nib),
        .clear_o (clear)
    );

    assign take = beat_valid && cfg.en && (beat_cs == cfg.cs);

    ecc_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .take_i  (take),
        .wide_i  (cfg.wide),
        .data_i  (beat_data),
        .size_i  (size),
        .even_o  (par_even),
        .odd_o   (par_odd),
        .done_o  (ecc_done)
    );

    always_comb begin
        result        = '0;
        result[7:0]   = par_even[7:0];
        result[11:8]  = par_even[TERMS-1:8];
        result[23:16] = par_odd[7:0];
        result[27:24] = par_odd[TERMS-1:8];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            ADDR_CFG: begin
                reg_rdata[0]      = cfg.en;
                reg_rdata[CS_W:1] = cfg.cs;
                reg_rdata[7]      = cfg.wide;
            end
            ADDR_CTRL:   reg_rdata[0] = ptr;
            ADDR_SIZE: begin
                reg_rdata[31:32-SIZE_W] = size;
                reg_rdata[3:0]          = nib;
            end
            default:     reg_rdata = result;
        endcase
    end
endmodule

// File: rtl/ecc_acc_chk.sv
module ecc_acc_chk
    import ecc_acc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            beat_valid,
    input logic [CS_W-1:0] beat_cs,
    input logic            cfg_en,
    input logic [CS_W-1:0] cfg_cs,
    input logic [31:0]     result,
    input logic            ecc_done
);
    logic clear_wr;
    assign clear_wr = reg_wr && (reg_addr == 2'd1) && reg_wdata[8];

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> (result == 32'd0 && !ecc_done));

    assert_done_only_falls_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ecc_done) |-> $past(clear_wr));

    assert_foreign_cs_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_cs != cfg_cs && !clear_wr) |=> $stable(result));

    assert_disabled_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !cfg_en && !clear_wr) |=> $stable(result));

    assert_done_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_done && !clear_wr) |=> ($stable(result) && ecc_done));
endmodule

bind ecc_hamming_acc ecc_acc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .beat_valid (beat_valid),
    .beat_cs    (beat_cs),
    .cfg_en     (cfg.en),
    .cfg_cs     (cfg.cs),
    .result     (result),
    .ecc_done   (ecc_done)
);

// File: tb/tb_ecc_hamming_acc.sv
module tb_ecc_hamming_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        beat_valid = 1'b0;
    logic [15:0] beat_data = '0;
    logic [2:0]  beat_cs = '0;
    logic        ecc_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mem [0:1023];

    always #5 clk = ~clk;

    ecc_hamming_acc dut (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model(input int nbytes);
        logic [11:0] ev = '0, od = '0;
        logic [31:0] r = '0;
        for (int i = 0; i < nbytes; i++)
            for (int b = 0; b < 8; b++)
                if (mem[i][b]) begin
                    for (int k = 0; k < 3; k++)
                        if ((b >> k) & 1) od[k] ^= 1'b1; else ev[k] ^= 1'b1;
                    for (int k = 0; k < 9; k++)
                        if ((i >> k) & 1) od[3+k] ^= 1'b1; else ev[3+k] ^= 1'b1;
                end
        r[7:0] = ev[7:0]; r[11:8] = ev[11:8];
        r[23:16] = od[7:0]; r[27:24] = od[11:8];
        return r;
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input int first, input int n, input logic wide, input logic [2:0] cs);
        for (int i = first; i < first + n; i++) begin
            @(negedge clk);
            beat_valid = 1'b1; beat_cs = cs;
            beat_data = wide ? {mem[2*i+1], mem[2*i]} : {8'h00, mem[i]};
        end
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(2'd3, d); check("R7 reset code", d, 32'd0);
        rd_reg(2'd0, d); check("R1 reset config", d, 32'd0);
        check("R10 reset done", {31'd0, ecc_done}, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(2'd0, 32'hFFFF_FF7B);
        rd_reg(2'd0, d); check("R1 config readback", d, 32'h0000_000B);
        wr_reg(2'd2, (32'd7 << 22) | 32'h0000_00AF);
        rd_reg(2'd2, d); check("R3 size readback", d, (32'd7 << 22) | 32'h0000_000F);
        wr_reg(2'd1, 32'h0000_0101);
        rd_reg(2'd1, d); check("R2 pointer readback", d, 32'd1);
    endtask

    task automatic t_x8();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
        wr_reg(2'd0, 32'h0000_0005);
        wr_reg(2'd2, (32'd7 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 16, 1'b0, 3'd2);
        rd_reg(2'd3, d); check("R4 R5 x8 sector code", d, model(16));
        check("R10 done after 16 bytes", {31'd0, ecc_done}, 32'd1);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        mem[5] = 8'h04;
        wr_reg(2'd0, 32'h0000_0005);
        wr_reg(2'd2, (32'd3 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 8, 1'b0, 3'd2);
        rd_reg(2'd3, d); check("R6 single-bit layout", d, 32'h002A_0FD5);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) mem[i] = 8'h01;
        wr_reg(2'd0, 32'h0000_0005);
        wr_reg(2'd2, (32'd3 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 4, 1'b0, 3'd3);
        rd_reg(2'd3, d); check("R8 foreign cs ignored", d, 32'd0);
        wr_reg(2'd0, 32'h0000_0004);
        send(0, 4, 1'b0, 3'd2);
        rd_reg(2'd3, d); check("R9 disabled ignored", d, 32'd0);
        wr_reg(2'd0, 32'h0000_0005);
        send(0, 1, 1'b0, 3'd2);
        rd_reg(2'd3, d); check("R8 count untouched by ignored beats", d, model(1));
    endtask

    task automatic t_done();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) mem[i] = 8'(8'hA1 + 8'(i * 19));
        wr_reg(2'd0, 32'h0000_0005);
        wr_reg(2'd2, (32'd1 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 3, 1'b0, 3'd2);
        check("R10 not done after 3 of 4", {31'd0, ecc_done}, 32'd0);
        send(3, 1, 1'b0, 3'd2);
        check("R10 done after 4 of 4", {31'd0, ecc_done}, 32'd1);
        send(4, 3, 1'b0, 3'd2);
        rd_reg(2'd3, d); check("R10 extra beats ignored", d, model(4));
        check("R10 done holds", {31'd0, ecc_done}, 32'd1);
        wr_reg(2'd1, 32'h100);
        rd_reg(2'd3, d); check("R2 clear zeroes code", d, 32'd0);
        check("R2 clear drops done", {31'd0, ecc_done}, 32'd0);
    endtask

    task automatic t_x16();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) mem[i] = 8'(8'h3C ^ 8'(i * 11));
        wr_reg(2'd0, 32'h0000_008D);
        wr_reg(2'd2, (32'd7 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 7, 1'b1, 3'd6);
        check("R11 not done after 7 words", {31'd0, ecc_done}, 32'd0);
        send(7, 1, 1'b1, 3'd6);
        check("R11 done after 8 words", {31'd0, ecc_done}, 32'd1);
        rd_reg(2'd3, d); check("R11 x16 low byte first", d, model(16));
    endtask

    task automatic t_erased();
        logic [31:0] d;
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        wr_reg(2'd0, 32'h0000_0003);
        wr_reg(2'd2, (32'd255 << 22) | 32'hF);
        wr_reg(2'd1, 32'h101);
        send(0, 512, 1'b0, 3'd1);
        rd_reg(2'd3, d); check("R7 erased sector code", d, 32'd0);
        check("R10 done after 512 bytes", {31'd0, ecc_done}, 32'd1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_regs();
                t_x8();
                t_layout();
                t_ignore();
                t_done();
                t_x16();
                t_erased();
            end
            begin
                repeat (50000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule